// File: doc/BRIEF.md
# Security-Banked Special Register Port

This block is the special-register read/write port of a small microcontroller core that can run in a secure or a non-secure state. It holds two banked copies, one per security state, of each of these registers: the main stack pointer, the process stack pointer, the interrupt disable mask, the priority mask, the fault mask and the control register. An 8-bit selector comes from the move-to and move-from special register instructions. The block returns read data combinationally. On a write strobe it commits write data on the next rising clock edge, after applying the access rules and the field masks.

Code running in the secure state can also reach the non-secure copies through a set of extra alias selectors. Code in the non-secure state cannot use these aliases: reads return zero and writes are dropped. There is also a privilege rule. Unprivileged code reads zero from nearly every register and cannot write any of them. A status output goes high whenever a write request is dropped.

Top module: `banked_sreg_port`

## Requirements
- R1: Reset clears every banked copy of the interrupt mask, priority mask, fault mask and control register to zero. It loads both main stack pointers with MSP_INIT and both process stack pointers with PSP_INIT.
- R2: Selectors 8 (main SP), 9 (process SP), 16 (interrupt mask), 17 (priority mask), 19 (fault mask) and 20 (control) reach the copy that belongs to the current security state. Any selector that is not listed in R2, R3 or R5 reads zero, and a write to it is dropped.
- R3: When SEC_EXT is 1 and the core is secure, these selectors reach the non-secure copies: 0x88 (main SP), 0x89 (process SP), 0x90 (interrupt mask), 0x91 (priority mask), 0x93 (fault mask) and 0x94 (control).
- R4: From the non-secure state, every alias selector (0x88, 0x89, 0x90, 0x91, 0x93, 0x94, 0x98) reads zero, and a write to one of them changes nothing.
- R5: Selector 0x98 reaches the non-secure process SP when the core is in thread mode (is_handler=0) and the non-secure control bit 1 (stack select) is 1. In every other case it reaches the non-secure main SP. The same rule applies to reads and to writes.
- R6: When is_priv=0, only selector 20 and the secure-state use of 0x94 return data; every other read returns zero. Every write is dropped.
- R7: A write keeps bit 0 of the value for the interrupt mask and the fault mask, bits 7:0 for the priority mask, and bits 1:0 for the control register. A stack pointer write keeps the full width.
- R8: `ignored` is 1 exactly when wr_en is 1 and the write commits nothing.
- R9: rd_data follows the inputs combinationally. A write becomes visible only after the rising clock edge on which wr_en is sampled.
- R10: With SEC_EXT=0, every alias selector reads zero and a write to one of them is dropped, whatever the security state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 8 | Special register selector |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write value |
| is_secure | input | 1 | 1 = core in secure state |
| is_priv | input | 1 | 1 = privileged execution |
| is_handler | input | 1 | 1 = handler mode, 0 = thread mode |
| rd_data | output | DW | Read value |
| ignored | output | 1 | Write request dropped |

## Verification
The assertions check on every cycle that non-secure alias reads and unprivileged reads return zero, and that `ignored` only appears together with a write strobe. They also check that a dropped write leaves all banked state unchanged, that an interrupt mask alias write keeps bit 0 only, and that thread-mode use of 0x98 returns the non-secure process SP. The bench scenarios are needed for the rest. Those cover the reset values, bank separation across long random sequences, the masking of every field and the same-cycle read-before-commit timing. They also compare a second build with SEC_EXT=0 against the full one.

// File: rtl/banked_sreg_port.sv
module banked_sreg_port #(
  parameter int DW = 32,
  parameter bit SEC_EXT = 1'b1,
  parameter logic [DW-1:0] MSP_INIT = DW'(32'h2000_1000),
  parameter logic [DW-1:0] PSP_INIT = DW'(32'h2000_0800)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          is_secure,
  input  logic          is_priv,
  input  logic          is_handler,
  output logic [DW-1:0] rd_data,
  output logic          ignored
);
  localparam int PRW = 8;
  localparam int CTW = 2;
  localparam int SPSEL = 1;

  typedef enum logic [2:0] {K_NONE, K_MSP, K_PSP, K_PM, K_PRI, K_FM, K_CTL} kind_t;

  logic [1:0][DW-1:0]  msp_q, psp_q;
  logic [1:0]          pm_q, fm_q;
  logic [1:0][PRW-1:0] pri_q;
  logic [1:0][CTW-1:0] ctl_q;

  kind_t kind;
  logic  bank;
  logic  open_unpriv;
  logic  rd_ok, wr_ok;

  always_comb begin
    kind = K_NONE;
    bank = is_secure;
    open_unpriv = 1'b0;
    case (sel)
      8'd8:  kind = K_MSP;
      8'd9:  kind = K_PSP;
      8'd16: kind = K_PM;
      8'd17: kind = K_PRI;
      8'd19: kind = K_FM;
      8'd20: begin kind = K_CTL; open_unpriv = 1'b1; end
      default: ;
    endcase
    if (SEC_EXT && is_secure) begin
      case (sel)
        8'h88: begin kind = K_MSP; bank = 1'b0; end
        8'h89: begin kind = K_PSP; bank = 1'b0; end
        8'h90: begin kind = K_PM;  bank = 1'b0; end
        8'h91: begin kind = K_PRI; bank = 1'b0; end
        8'h93: begin kind = K_FM;  bank = 1'b0; end
        8'h94: begin kind = K_CTL; bank = 1'b0; open_unpriv = 1'b1; end
        8'h98: begin
          kind = (!is_handler && ctl_q[0][SPSEL]) ? K_PSP : K_MSP;
          bank = 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign rd_ok   = (kind != K_NONE) && (is_priv || open_unpriv);
  assign wr_ok   = wr_en && (kind != K_NONE) && is_priv;
  assign ignored = wr_en && !wr_ok;

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      case (kind)
        K_MSP: rd_data = msp_q[bank];
        K_PSP: rd_data = psp_q[bank];
        K_PM:  rd_data = DW'(pm_q[bank]);
        K_PRI: rd_data = DW'(pri_q[bank]);
        K_FM:  rd_data = DW'(fm_q[bank]);
        K_CTL: rd_data = DW'(ctl_q[bank]);
        default: rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msp_q <= {2{MSP_INIT}};
      psp_q <= {2{PSP_INIT}};
      pm_q  <= '0;
      fm_q  <= '0;
      pri_q <= '0;
      ctl_q <= '0;
    end else if (wr_ok) begin
      case (kind)
        K_MSP: msp_q[bank] <= wr_data;
        K_PSP: psp_q[bank] <= wr_data;
        K_PM:  pm_q[bank]  <= wr_data[0];
        K_PRI: pri_q[bank] <= wr_data[PRW-1:0];
        K_FM:  fm_q[bank]  <= wr_data[0];
        K_CTL: ctl_q[bank] <= wr_data[CTW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/banked_sreg_port_chk.sv
module banked_sreg_port_chk #(
  parameter int DW = 32,
  parameter bit SEC_EXT = 1'b1
)(
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          sel,
  input logic                wr_en,
  input logic [DW-1:0]       wr_data,
  input logic                is_secure,
  input logic                is_priv,
  input logic                is_handler,
  input logic [DW-1:0]       rd_data,
  input logic                ignored,
  input logic [1:0][DW-1:0]  msp,
  input logic [1:0][DW-1:0]  psp,
  input logic [1:0]          pm,
  input logic [1:0]          fm,
  input logic [1:0][7:0]     pri,
  input logic [1:0][1:0]     ctl
);
  logic is_alias;
  assign is_alias = (sel == 8'h88) || (sel == 8'h89) || (sel == 8'h90) || (sel == 8'h91) ||
                    (sel == 8'h93) || (sel == 8'h94) || (sel == 8'h98);

  // R4
  ns_alias_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_secure && is_alias) |-> (rd_data == '0));

  // R6
  unpriv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_priv && sel != 8'd20 && sel != 8'h94) |-> (rd_data == '0));

  // R8
  ignored_has_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignored |-> wr_en);

  // R8
  ignored_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignored |=> $stable({msp, psp, pm, fm, pri, ctl}));

  // R7
  pm_alias_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ignored && is_secure && sel == 8'h90) |=> (pm[0] == $past(wr_data[0])));

  // R5
  sp_alias_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SEC_EXT && is_secure && is_priv && !is_handler && ctl[0][1] && sel == 8'h98)
      |-> (rd_data == psp[0]));
endmodule

bind banked_sreg_port banked_sreg_port_chk #(.DW(DW), .SEC_EXT(SEC_EXT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
  .is_secure(is_secure), .is_priv(is_priv), .is_handler(is_handler),
  .rd_data(rd_data), .ignored(ignored),
  .msp(msp_q), .psp(psp_q), .pm(pm_q), .fm(fm_q), .pri(pri_q), .ctl(ctl_q)
);

// File: tb/banked_sreg_port_test.sv
`timescale 1ns/1ps
module banked_sreg_port_test;
  localparam logic [31:0] MSPI = 32'h2000_1000;
  localparam logic [31:0] PSPI = 32'h2000_0800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] sel = '0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic is_secure = 1'b0, is_priv = 1'b0, is_handler = 1'b0;
  logic [31:0] rd_data, rd_n;
  logic ignored, ign_n;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  banked_sreg_port #(.DW(32), .SEC_EXT(1'b1), .MSP_INIT(MSPI), .PSP_INIT(PSPI)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .is_secure(is_secure), .is_priv(is_priv), .is_handler(is_handler),
    .rd_data(rd_data), .ignored(ignored));

  banked_sreg_port #(.DW(32), .SEC_EXT(1'b0), .MSP_INIT(MSPI), .PSP_INIT(PSPI)) uut_nosec (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .is_secure(is_secure), .is_priv(is_priv), .is_handler(is_handler),
    .rd_data(rd_n), .ignored(ign_n));

  logic [31:0] m_msp [2], m_psp [2];
  logic        m_pm [2], m_fm [2];
  logic [7:0]  m_pri [2];
  logic [1:0]  m_ctl [2];

  function automatic bit alias_sel(input logic [7:0] s);
    return s == 8'h88 || s == 8'h89 || s == 8'h90 || s == 8'h91 ||
           s == 8'h93 || s == 8'h94 || s == 8'h98;
  endfunction

  function automatic void resolve(input logic [7:0] s, input logic sc, input logic hd,
                                  output int k, output int b, output bit open);
    k = 0; b = sc ? 1 : 0; open = 0;
    case (s)
      8'd8: k = 1;  8'd9: k = 2;  8'd16: k = 3;  8'd17: k = 4;  8'd19: k = 5;
      8'd20: begin k = 6; open = 1; end
      default: ;
    endcase
    if (sc && alias_sel(s)) begin
      b = 0;
      case (s)
        8'h88: k = 1; 8'h89: k = 2; 8'h90: k = 3; 8'h91: k = 4; 8'h93: k = 5;
        8'h94: begin k = 6; open = 1; end
        default: k = (!hd && m_ctl[0][1]) ? 2 : 1;
      endcase
    end
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] s, input logic sc, pv, hd);
    int k, b; bit open;
    resolve(s, sc, hd, k, b, open);
    if (k == 0 || (!pv && !open)) return 32'h0;
    case (k)
      1: return m_msp[b];
      2: return m_psp[b];
      3: return {31'h0, m_pm[b]};
      4: return {24'h0, m_pri[b]};
      5: return {31'h0, m_fm[b]};
      default: return {30'h0, m_ctl[b]};
    endcase
  endfunction

  function automatic logic exp_ign(input logic [7:0] s, input logic w, sc, pv, hd);
    int k, b; bit open;
    resolve(s, sc, hd, k, b, open);
    return w && (k == 0 || !pv);
  endfunction

  function automatic void model_wr(input logic [7:0] s, input logic [31:0] d, input logic sc, pv, hd);
    int k, b; bit open;
    resolve(s, sc, hd, k, b, open);
    if (k == 0 || !pv) return;
    case (k)
      1: m_msp[b] = d;
      2: m_psp[b] = d;
      3: m_pm[b]  = d[0];
      4: m_pri[b] = d[7:0];
      5: m_fm[b]  = d[0];
      default: m_ctl[b] = d[1:0];
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] s, input logic sc, pv);
    if (!pv) return "R6";
    if (alias_sel(s) && !sc) return "R4";
    if (s == 8'h98) return "R5";
    if (alias_sel(s)) return "R3";
    return "R2";
  endfunction

  task automatic step(input logic [7:0] s, input logic w, input logic [31:0] d,
                      input logic sc, pv, hd, input string tag);
    @(negedge clk);
    sel = s; wr_en = w; wr_data = d; is_secure = sc; is_priv = pv; is_handler = hd;
    #1;
    check(tag, rd_data, exp_rd(s, sc, pv, hd));
    check("R8", {31'h0, ignored}, {31'h0, exp_ign(s, w, sc, pv, hd)});
    if (alias_sel(s)) begin
      check("R10", rd_n, 32'h0);
      check("R10", {31'h0, ign_n}, {31'h0, w});
    end
    @(posedge clk);
    if (w) model_wr(s, d, sc, pv, hd);
  endtask

  task automatic look(input logic [7:0] s, input logic sc, pv, hd,
                      input logic [31:0] lit, input string tag);
    @(negedge clk);
    sel = s; wr_en = 1'b0; is_secure = sc; is_priv = pv; is_handler = hd;
    #1;
    check(tag, rd_data, lit);
    check(tag, rd_data, exp_rd(s, sc, pv, hd));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] pool [13];
    int r;
    pool = '{8'd8, 8'd9, 8'd16, 8'd17, 8'd19, 8'd20, 8'h88, 8'h89, 8'h90, 8'h91, 8'h93, 8'h94, 8'h98};
    for (int i = 0; i < 2; i++) begin
      m_msp[i] = MSPI; m_psp[i] = PSPI; m_pm[i] = 0; m_fm[i] = 0; m_pri[i] = 0; m_ctl[i] = 0;
    end
    r = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    look(8'd8, 1, 1, 0, MSPI, "R1");
    look(8'h89, 1, 1, 0, PSPI, "R1");
    look(8'd20, 0, 1, 0, 32'h0, "R1");
    look(8'h91, 1, 1, 0, 32'h0, "R1");

    step(8'h91, 1, 32'hFFFF_FFFF, 1, 1, 0, "R7");
    look(8'h91, 1, 1, 0, 32'hFF, "R7");
    look(8'd17, 1, 1, 0, 32'h0, "R3");
    look(8'd17, 0, 1, 0, 32'hFF, "R3");
    step(8'd16, 1, 32'hFFFF_FFFE, 1, 1, 0, "R7");
    look(8'd16, 1, 1, 0, 32'h0, "R7");
    step(8'd19, 1, 32'h3, 0, 1, 0, "R2");
    look(8'h93, 1, 1, 0, 32'h1, "R2");
    step(8'd20, 1, 32'hF, 1, 1, 0, "R7");
    look(8'd20, 1, 1, 0, 32'h3, "R7");

    step(8'h94, 1, 32'h2, 1, 1, 0, "R3");
    look(8'd20, 0, 0, 0, 32'h2, "R6");
    step(8'h89, 1, 32'h1111_0000, 1, 1, 0, "R3");
    step(8'h88, 1, 32'h2222_0000, 1, 1, 0, "R3");
    look(8'h98, 1, 1, 0, 32'h1111_0000, "R5");
    look(8'h98, 1, 1, 1, 32'h2222_0000, "R5");
    step(8'h98, 1, 32'h3333_0000, 1, 1, 0, "R5");
    look(8'h89, 1, 1, 0, 32'h3333_0000, "R5");
    step(8'h98, 1, 32'h5555_0000, 1, 1, 1, "R5");
    look(8'h88, 1, 1, 0, 32'h5555_0000, "R5");

    step(8'h88, 1, 32'hDEAD, 0, 1, 0, "R4");
    look(8'h88, 1, 1, 0, 32'h5555_0000, "R4");
    look(8'h88, 0, 1, 0, 32'h0, "R4");

    look(8'h94, 1, 0, 0, 32'h2, "R6");
    look(8'h94, 0, 0, 0, 32'h0, "R6");
    look(8'd8, 1, 0, 0, 32'h0, "R6");
    step(8'd16, 1, 32'h1, 1, 0, 0, "R6");
    look(8'd16, 1, 1, 0, 32'h0, "R6");

    step(8'd9, 1, 32'h4444, 1, 1, 0, "R9");
    look(8'd9, 1, 1, 0, 32'h4444, "R9");
    look(8'h42, 1, 1, 0, 32'h0, "R2");

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] s;
      logic sc, pv, hd, w;
      logic [31:0] d;
      s  = ($urandom % 8 == 0) ? 8'($urandom) : pool[$urandom % 13];
      sc = 1'($urandom); pv = ($urandom % 4) != 0; hd = 1'($urandom);
      w  = 1'($urandom); d = $urandom;
      step(s, w, d, sc, pv, hd, tag_of(s, sc, pv));
    end

    @(negedge clk) wr_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule